// File: doc/BRIEF.md
# Dual-Edge Converter Sample Capture Receiver

This block receives the parallel output of a high-speed data converter: a 14-bit sample word and an over-range bit, sent together with a data-ready strobe. The strobe runs at half the converter's sample rate, and a fresh word appears on every strobe transition, rising and falling alike. The receiver samples the strobe and the data lines in its own clock, which must be fast enough to see every strobe level. It detects each strobe transition and captures the word that belongs to it. It emits the captured words as a single-rate stream, one valid pulse per word, in the order they arrived.

The converter codes samples in offset binary. The receiver emits them in two's complement, and each one carries its own over-range flag. The strobe's polarity at start-up is not defined, so framing follows transitions only. The first transition after reset, in either direction, starts sample 0. The strobe and data leave the converter edge-aligned. A selectable delay of 0 to 7 receiver-clock stages on the data path sets which registered data word a strobe transition picks up. A sticky over-range bit records that some sample was flagged, until a clear input resets it.

Top module: `ddr_adc_capture`

## Requirements
- R1: While reset is asserted (rstN low), sampleValid, sampleFirst, sampleOvr, samplePhase and stickyOvr are 0 and sampleOut is all zeros.
- R2: Each strobe transition produces exactly one single-cycle sampleValid pulse. If the strobe changes before clock edge k, sampleValid is high for the cycle after edge k+1 and low again after edge k+2.
- R3: After reset is released, the strobe level held at the first two clock edges is taken as the idle level and produces no sample. The first transition after that, rising or falling, yields sample 0. sampleFirst is high together with sampleValid for that sample only.
- R4: Samples leave in strict arrival order, one output per strobe transition, none dropped or repeated.
- R5: sampleOut is the captured word with bit 13 inverted (offset binary to two's complement). Input 0x0000 gives 0x2000, 0x3FFF gives 0x1FFF, 0x2000 gives 0x0000 and 0x1FFF gives 0x3FFF.
- R6: sampleOvr, valid with sampleValid, equals the over-range input captured together with that same word.
- R7: samplePhase, valid with sampleValid, is the strobe level after the transition that carried the sample: 1 for a rising transition and 0 for a falling one.
- R8: For a dataDelay value d, a transition on the strobe first registered at clock edge k captures the data and over-range inputs that were registered at clock edge k-d.
- R9: stickyOvr goes high on the same edge that delivers a sample with sampleOvr high.
- R10: While clearOvr is high at a clock edge, stickyOvr goes to 0 unless that same edge delivers a flagged sample, in which case it stays 1. Without clearOvr it holds its value.
- R11: Changes on dataIn or ovrIn while the strobe stays put produce no sampleValid and leave sampleOut unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobeIn | input | 1 | Data-ready strobe from the converter, half the sample rate |
| dataIn | input | 14 | Offset-binary sample word, bit 13 most significant |
| ovrIn | input | 1 | Over-range bit travelling with dataIn |
| dataDelay | input | 3 | Number of extra register stages on the data path (0 to 7) |
| clearOvr | input | 1 | Clears the sticky over-range bit |
| sampleOut | output | 14 | Captured sample in two's complement |
| sampleValid | output | 1 | One-cycle pulse per captured sample |
| sampleOvr | output | 1 | Over-range flag of the current sample |
| samplePhase | output | 1 | Strobe level after the carrying transition |
| sampleFirst | output | 1 | Marks sample 0 after reset |
| stickyOvr | output | 1 | Sticky over-range status |

## Verification
A clear request and the arrival of a flagged sample can land on the same clock edge, and then they contend for the sticky status bit. The bench raises clearOvr exactly on the edge that delivers a captured word. It does this once with the over-range bit low and once with it high. The first case must leave the status at 0, and the second must leave it at 1 because the new flag wins. A bare clear with no sample must then bring the status back to 0.

// File: rtl/ddr_adc_capture_pkg.sv
package ddr_adc_capture_pkg;

  // Strobes from framing control to the capture datapath
  typedef struct packed {
    logic capture;  // a strobe transition was seen this cycle
    logic phase;    // strobe level after that transition
    logic first;    // transition is sample 0 since reset
  } rxStrobe_t;

  localparam int unsigned WARM_EDGES = 2;

endpackage

// File: rtl/ddr_adc_capture_ctrl.sv
module ddr_adc_capture_ctrl
  import ddr_adc_capture_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobeIn,
  output rxStrobe_t  ctrl
);

  localparam int unsigned WARM_W = $clog2(WARM_EDGES + 1);

  logic              strbQ;
  logic              strbPrev;
  logic [WARM_W-1:0] warmCnt;
  logic              seenFirst;
  logic              warmDone;
  logic              transition;

  assign warmDone   = (warmCnt == WARM_W'(WARM_EDGES));
  assign transition = warmDone && (strbQ != strbPrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strbQ     <= 1'b0;
      strbPrev  <= 1'b0;
      warmCnt   <= '0;
      seenFirst <= 1'b0;
    end else begin
      strbQ    <= strobeIn;
      strbPrev <= strbQ;
      if (!warmDone) warmCnt <= warmCnt + 1'b1;
      if (transition) seenFirst <= 1'b1;
    end
  end

  always_comb begin
    ctrl.capture = transition;
    ctrl.phase   = strbQ;
    ctrl.first   = transition && !seenFirst;
  end

endmodule

// File: rtl/ddr_adc_capture_dp.sv
module ddr_adc_capture_dp
  import ddr_adc_capture_pkg::*;
#(
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned DLY_STAGES = 8,
  localparam int unsigned DLY_W     = $clog2(DLY_STAGES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ovrIn,
  input  logic [DLY_W-1:0]  dataDelay,
  input  logic              clearOvr,
  input  rxStrobe_t         ctrl,
  output logic [DATA_W-1:0] sampleOut,
  output logic              sampleValid,
  output logic              sampleOvr,
  output logic              samplePhase,
  output logic              sampleFirst,
  output logic              stickyOvr
);

  localparam int unsigned WORD_W = DATA_W + 1;  // over-range bit on top

  logic [WORD_W-1:0] lineReg [DLY_STAGES];
  logic [WORD_W-1:0] selWord;

  for (genvar i = 0; i < DLY_STAGES; i++) begin : g_line
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) lineReg[0] <= '0;
        else       lineReg[0] <= {ovrIn, dataIn};
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rstN) lineReg[i] <= '0;
        else       lineReg[i] <= lineReg[i-1];
      end
    end
  end

  assign selWord = lineReg[dataDelay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
      sampleOvr   <= 1'b0;
      samplePhase <= 1'b0;
      sampleFirst <= 1'b0;
      stickyOvr   <= 1'b0;
    end else begin
      sampleValid <= ctrl.capture;
      sampleFirst <= ctrl.first;
      if (ctrl.capture) begin
        sampleOut   <= {~selWord[DATA_W-1], selWord[DATA_W-2:0]};
        sampleOvr   <= selWord[DATA_W];
        samplePhase <= ctrl.phase;
      end
      // a flagged sample on the clearing edge wins
      stickyOvr <= (stickyOvr && !clearOvr) || (ctrl.capture && selWord[DATA_W]);
    end
  end

endmodule

// File: rtl/ddr_adc_capture.sv
module ddr_adc_capture
  import ddr_adc_capture_pkg::*;
#(
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned DLY_STAGES = 8
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          strobeIn,
  input  logic [DATA_W-1:0]             dataIn,
  input  logic                          ovrIn,
  input  logic [$clog2(DLY_STAGES)-1:0] dataDelay,
  input  logic                          clearOvr,
  output logic [DATA_W-1:0]             sampleOut,
  output logic                          sampleValid,
  output logic                          sampleOvr,
  output logic                          samplePhase,
  output logic                          sampleFirst,
  output logic                          stickyOvr
);

  rxStrobe_t ctrlStrb;

  ddr_adc_capture_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobeIn (strobeIn),
    .ctrl     (ctrlStrb)
  );

  ddr_adc_capture_dp #(
    .DATA_W     (DATA_W),
    .DLY_STAGES (DLY_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .ovrIn       (ovrIn),
    .dataDelay   (dataDelay),
    .clearOvr    (clearOvr),
    .ctrl        (ctrlStrb),
    .sampleOut   (sampleOut),
    .sampleValid (sampleValid),
    .sampleOvr   (sampleOvr),
    .samplePhase (samplePhase),
    .sampleFirst (sampleFirst),
    .stickyOvr   (stickyOvr)
  );

endmodule

// File: rtl/ddr_adc_capture_chk.sv
module ddr_adc_capture_chk (
  input logic clk,
  input logic rstN,
  input logic strobeIn,
  input logic clearOvr,
  input logic sampleValid,
  input logic sampleOvr,
  input logic samplePhase,
  input logic sampleFirst,
  input logic stickyOvr
);

  logic firstSeen;

  always_ff @(posedge clk) begin
    if (!rstN)            firstSeen <= 1'b0;
    else if (sampleFirst) firstSeen <= 1'b1;
  end

  AST_VALID_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> ($past(strobeIn, 2) != $past(strobeIn, 3))); // R2

  AST_PHASE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (samplePhase == $past(strobeIn, 2))); // R7

  AST_FIRST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    sampleFirst |-> sampleValid); // R3

  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    sampleFirst |-> !firstSeen); // R3

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleOvr) |-> stickyOvr); // R9

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stickyOvr && !clearOvr) |=> stickyOvr); // R10

endmodule

bind ddr_adc_capture ddr_adc_capture_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .strobeIn    (strobeIn),
  .clearOvr    (clearOvr),
  .sampleValid (sampleValid),
  .sampleOvr   (sampleOvr),
  .samplePhase (samplePhase),
  .sampleFirst (sampleFirst),
  .stickyOvr   (stickyOvr)
);

// File: tb/ddr_adc_capture_bench.sv
`timescale 1ns/1ps
module ddr_adc_capture_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strobeIn = 1'b0;
  logic [13:0] dataIn = '0;
  logic        ovrIn = 1'b0;
  logic [2:0]  dataDelay = '0;
  logic        clearOvr = 1'b0;
  logic [13:0] sampleOut;
  logic        sampleValid, sampleOvr, samplePhase, sampleFirst, stickyOvr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // capture log filled by the monitor
  logic [13:0] gotWord  [256];
  logic        gotOvr   [256];
  logic        gotPhase [256];
  logic        gotFirst [256];
  int          gotN = 0;

  always #2.5 clk = ~clk;

  ddr_adc_capture u_ddr_adc_capture (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .dataIn(dataIn), .ovrIn(ovrIn),
    .dataDelay(dataDelay), .clearOvr(clearOvr), .sampleOut(sampleOut),
    .sampleValid(sampleValid), .sampleOvr(sampleOvr), .samplePhase(samplePhase),
    .sampleFirst(sampleFirst), .stickyOvr(stickyOvr)
  );

  always @(negedge clk) begin
    if (rstN && sampleValid && gotN < 256) begin
      gotWord[gotN]  = sampleOut;
      gotOvr[gotN]   = sampleOvr;
      gotPhase[gotN] = samplePhase;
      gotFirst[gotN] = sampleFirst;
      gotN++;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic doReset(input logic level);
    @(negedge clk);
    rstN = 1'b0; strobeIn = level; dataIn = '0; ovrIn = 1'b0; clearOvr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // one word per strobe transition; the strobe lags the data by three cycles
  task automatic sendWord(input logic [13:0] w, input logic ovr, input logic clr);
    dataIn = w; ovrIn = ovr;
    repeat (3) @(negedge clk);
    strobeIn = ~strobeIn;
    @(negedge clk);
    clearOvr = clr;
    @(negedge clk);
    clearOvr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(sampleValid == 0 && sampleFirst == 0 && sampleOvr == 0 && samplePhase == 0
          && stickyOvr == 0 && sampleOut == 0, "R1 reset state",
          {sampleValid, sampleFirst, sampleOvr, samplePhase, stickyOvr, sampleOut}, 0);
  endtask

  task automatic testLatency;
    doReset(1'b0);
    strobeIn = 1'b1;                       // sampled at the next edge k
    @(negedge clk);
    check(sampleValid == 0, "R2 no valid after edge k", sampleValid, 0);
    @(negedge clk);
    check(sampleValid == 1, "R2 valid after edge k+1", sampleValid, 1);
    @(negedge clk);
    check(sampleValid == 0, "R2 single-cycle pulse", sampleValid, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic testFirstPolarity(input logic level);
    int base;
    doReset(level);
    base = gotN;
    sendWord(14'h0101, 1'b0, 1'b0);
    sendWord(14'h0202, 1'b0, 1'b0);
    sendWord(14'h0303, 1'b0, 1'b0);
    sendWord(14'h0404, 1'b0, 1'b0);
    check(gotN - base == 4, "R3 one sample per transition, idle level ignored", gotN - base, 4);
    check(gotFirst[base] == 1, "R3 first flag on sample 0", gotFirst[base], 1);
    for (int i = 1; i < 4; i++)
      check(gotFirst[base+i] == 0, "R3 first flag only once", gotFirst[base+i], 0);
    for (int i = 0; i < 4; i++) begin
      logic expPh;
      expPh = (i % 2 == 0) ? ~level : level;
      check(gotPhase[base+i] == expPh, "R7 phase follows transition", gotPhase[base+i], expPh);
    end
    check(gotWord[base] == 14'h2101, "R3 sample 0 carries first word", gotWord[base], 14'h2101);
  endtask

  task automatic testConversion;
    logic [13:0] inW  [5] = '{14'h0000, 14'h3FFF, 14'h2000, 14'h1FFF, 14'h1234};
    logic [13:0] expW [5] = '{14'h2000, 14'h1FFF, 14'h0000, 14'h3FFF, 14'h3234};
    int base;
    base = gotN;
    for (int i = 0; i < 5; i++) sendWord(inW[i], 1'b0, 1'b0);
    check(gotN - base == 5, "R4 count", gotN - base, 5);
    for (int i = 0; i < 5; i++)
      check(gotWord[base+i] == expW[i], "R5 R4 converted word in order", gotWord[base+i], expW[i]);
  endtask

  task automatic testOvr;
    logic pat [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    int base;
    doReset(1'b1);
    check(stickyOvr == 0, "R9 sticky clear after reset", stickyOvr, 0);
    base = gotN;
    sendWord(14'h0010, pat[0], 1'b0);
    check(stickyOvr == 0, "R9 no flag yet", stickyOvr, 0);
    for (int i = 1; i < 4; i++) sendWord(14'h0010 + 14'(i), pat[i], 1'b0);
    for (int i = 0; i < 4; i++)
      check(gotOvr[base+i] == pat[i], "R6 over-range per sample", gotOvr[base+i], pat[i]);
    check(stickyOvr == 1, "R9 sticky set by flagged sample", stickyOvr, 1);
  endtask

  task automatic testClear;
    sendWord(14'h0AAA, 1'b0, 1'b1);
    check(stickyOvr == 0, "R10 clear with clean sample", stickyOvr, 0);
    sendWord(14'h0BBB, 1'b1, 1'b0);
    check(stickyOvr == 1, "R10 set again", stickyOvr, 1);
    sendWord(14'h0CCC, 1'b1, 1'b1);
    check(stickyOvr == 1, "R10 flagged sample wins over clear", stickyOvr, 1);
    repeat (4) @(negedge clk);
    check(stickyOvr == 1, "R10 holds without clear", stickyOvr, 1);
    clearOvr = 1'b1;
    @(negedge clk);
    clearOvr = 1'b0;
    check(stickyOvr == 0, "R10 bare clear", stickyOvr, 0);
  endtask

  task automatic testDelay(input int d);
    int base;
    logic [13:0] expW;
    dataDelay = 3'(d);
    sendWord(14'h0555, 1'b0, 1'b0);
    base = gotN;
    sendWord(14'h0666, 1'b0, 1'b0);
    expW = (d <= 3) ? 14'h2666 : 14'h2555;
    check(gotN - base == 1, "R8 one capture", gotN - base, 1);
    check(gotWord[base] == expW, $sformatf("R8 delay %0d selects word", d), gotWord[base], expW);
  endtask

  task automatic testIdle;
    logic [13:0] held;
    int base;
    dataDelay = '0;
    held = sampleOut;
    base = gotN;
    for (int i = 0; i < 20; i++) begin
      dataIn = 14'(i * 37); ovrIn = i[0];
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(gotN == base, "R11 no valid without strobe change", gotN - base, 0);
    check(sampleOut == held, "R11 output unchanged", sampleOut, held);
  endtask

  initial begin
    testReset();
    testLatency();
    testFirstPolarity(1'b0);
    testFirstPolarity(1'b1);
    testConversion();
    testOvr();
    testClear();
    testDelay(0);
    testDelay(3);
    testDelay(4);
    testDelay(7);
    testIdle();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule